// File: doc/BRIEF.md
# Command Ring Fetcher

This block drains a ring of fixed-size commands that software places in memory. Software programs the ring's page-aligned base address, its length in 4 KB pages and a valid bit. It then moves a producer offset forward as it writes commands. The block keeps its own consumer offset. Whenever the two offsets differ, fetching is permitted and no error is latched, so the block reads the next 32-byte command as four 64-bit words over a single-outstanding request/grant/response memory port. It then presents the whole command to an executor through a valid/ready handshake.

Both offsets count in bytes. The consumer offset moves forward by one command only after the executor accepts it, and it returns to zero at the end of the ring. The ring is drained, and `idle_o` is high, exactly when the offsets are equal. A producer offset that points outside the ring latches a sticky error, and fetching stops.

Top module: `cmdq_fetch`

## Requirements
- R1: After reset the consumer and producer offsets read back as 0, the enable bit reads 0, `idle_o` is 1, and `err_o`, `mem_req_o` and `cmd_valid_o` are 0.
- R2: A new command fetch starts only when the enable bit (register 0, bit 0) is set, the valid bit (register 1, bit 63) is set, no error is latched and the offsets differ. If either bit is clear, no memory request is made even when commands are pending.
- R3: A command is fetched with four reads issued one at a time, at byte addresses base + consumer offset + 8*i for i = 0..3 in increasing order. Each request holds its address until it is granted.
- R4: The word read for index i is placed in `cmd_o[64*i+63:64*i]`, so that word 0 sits in the least significant bits.
- R5: `cmd_valid_o` stays high and `cmd_o` stays stable until `cmd_ready_i` is sampled high.
- R6: The consumer offset changes only when a command is accepted. It then moves forward by 32, and it becomes 0 when the sum reaches the ring length (size field + 1) * 4096. The size field is register 1, bits [SIZE_W-1:0], and the base address is register 1, bits [ADDR_W-1:12].
- R7: `idle_o` is high exactly when the consumer offset equals the producer offset.
- R8: The producer offset (register 2) stores only 32-byte-aligned values. Bits [4:0] of a software write are dropped, and it reads back with those bits zero.
- R9: A write to the producer offset whose aligned value is at or above the ring length sets `err_o`. `err_o` stays set until reset, and while it is set `mem_req_o` stays low.
- R10: The consumer offset (register 3) is read-only, so software writes to it leave its value unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select: 0 control, 1 ring base, 2 producer offset, 3 consumer offset |
| reg_wdata_i | input | 64 | Register write data |
| reg_rdata_o | output | 64 | Read data of the selected register |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | ADDR_W | Byte address of the requested word |
| mem_gnt_i | input | 1 | Request accepted |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 64 | Read data |
| cmd_valid_o | output | 1 | Assembled command available |
| cmd_ready_i | input | 1 | Executor accepts the command |
| cmd_o | output | 256 | Assembled command, word 0 in the low bits |
| idle_o | output | 1 | Ring drained |
| err_o | output | 1 | Sticky producer-offset range error |

## Verification
The properties assume that the memory returns exactly one response for each granted request and returns nothing unrequested. They also assume that the ring base and size are not rewritten while a command is in flight. The stimulus respects both assumptions. The bench's memory responder answers only granted requests, after a random delay and with a random grant stall. Base and size writes are made only after the bench has waited for `idle_o`. Resets are likewise applied only when the ring is drained. Producer offsets are drawn at random inside the ring, with random junk in the low bits, except for the one directed out-of-range write that exercises the error path.

// File: rtl/cmdq_fetch_pkg.sv
package cmdq_fetch_pkg;
  localparam int unsigned CMD_WORDS  = 4;
  localparam int unsigned WORD_W     = 64;
  localparam int unsigned CMD_BYTES  = CMD_WORDS * WORD_W / 8;
  localparam int unsigned PAGE_LG    = 12;
  localparam int unsigned ALIGN_LG   = 5;
  localparam int unsigned VALID_BIT  = 63;

  typedef enum logic [1:0] {
    RA_CTRL = 2'd0,
    RA_BASE = 2'd1,
    RA_WOFF = 2'd2,
    RA_ROFF = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_REQ,
    S_WAIT,
    S_OUT
  } fetch_st_e;
endpackage

// File: rtl/cmdq_regs.sv
module cmdq_regs
  import cmdq_fetch_pkg::*;
#(
  parameter int unsigned ADDR_W = 40,
  parameter int unsigned SIZE_W = 8,
  localparam int unsigned OFF_W = SIZE_W + PAGE_LG
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [1:0]        addr_i,
  input  logic [63:0]       wdata_i,
  output logic [63:0]       rdata_o,
  input  logic              adv_i,
  output logic [ADDR_W-1:0] base_o,
  output logic [OFF_W-1:0]  roff_o,
  output logic [OFF_W:0]    qlen_o,
  output logic              start_ok_o,
  output logic              idle_o,
  output logic              err_o
);
  logic                     en_q, valid_q, err_q;
  logic [ADDR_W-PAGE_LG-1:0] pg_q;
  logic [SIZE_W-1:0]        size_q;
  logic [OFF_W-1:0]         woff_q, roff_q;
  logic [SIZE_W:0]          npages;
  logic [OFF_W:0]           wr_aligned, roff_sum;
  logic                     wr_high;

  assign npages     = {1'b0, size_q} + 1'b1;
  assign qlen_o     = {npages, {PAGE_LG{1'b0}}};
  assign wr_aligned = {wdata_i[OFF_W:ALIGN_LG], {ALIGN_LG{1'b0}}};
  assign wr_high    = |wdata_i[63:OFF_W+1];
  assign roff_sum   = {1'b0, roff_q} + (OFF_W+1)'(CMD_BYTES);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      valid_q <= 1'b0;
      pg_q    <= '0;
      size_q  <= '0;
      woff_q  <= '0;
      err_q   <= 1'b0;
    end else if (we_i) begin
      unique case (reg_sel_e'(addr_i))
        RA_CTRL: en_q <= wdata_i[0];
        RA_BASE: begin
          valid_q <= wdata_i[VALID_BIT];
          pg_q    <= wdata_i[ADDR_W-1:PAGE_LG];
          size_q  <= wdata_i[SIZE_W-1:0];
        end
        RA_WOFF: begin
          woff_q <= wr_aligned[OFF_W-1:0];
          if (wr_high || wr_aligned >= qlen_o) err_q <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  // consumer offset: moves only on acceptance, wraps at ring end
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     roff_q <= '0;
    else if (adv_i)  roff_q <= (roff_sum >= qlen_o) ? '0 : roff_sum[OFF_W-1:0];
  end

  always_comb begin
    rdata_o = '0;
    unique case (reg_sel_e'(addr_i))
      RA_CTRL: rdata_o[0] = en_q;
      RA_BASE: begin
        rdata_o[VALID_BIT]          = valid_q;
        rdata_o[ADDR_W-1:PAGE_LG]   = pg_q;
        rdata_o[SIZE_W-1:0]         = size_q;
      end
      RA_WOFF: rdata_o[OFF_W-1:0] = woff_q;
      RA_ROFF: rdata_o[OFF_W-1:0] = roff_q;
      default: ;
    endcase
  end

  assign base_o     = {pg_q, {PAGE_LG{1'b0}}};
  assign roff_o     = roff_q;
  assign idle_o     = (roff_q == woff_q);
  assign err_o      = err_q;
  assign start_ok_o = en_q && valid_q && !err_q && !idle_o;
endmodule

// File: rtl/cmdq_seq.sv
module cmdq_seq
  import cmdq_fetch_pkg::*;
#(
  parameter int unsigned ADDR_W = 40,
  parameter int unsigned OFF_W  = 20,
  localparam int unsigned IDX_W = $clog2(CMD_WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_ok_i,
  input  logic              err_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [OFF_W-1:0]  roff_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_gnt_i,
  input  logic              mem_rvalid_i,
  output logic              load_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              cmd_valid_o,
  input  logic              cmd_ready_i,
  output logic              adv_o
);
  fetch_st_e        st_q, st_d;
  logic [IDX_W-1:0] idx_q, idx_d;

  always_comb begin
    st_d  = st_q;
    idx_d = idx_q;
    unique case (st_q)
      S_IDLE: if (start_ok_i) begin
        st_d  = S_REQ;
        idx_d = '0;
      end
      S_REQ:  if (mem_gnt_i && !err_i) st_d = S_WAIT;
      S_WAIT: if (mem_rvalid_i) begin
        if (idx_q == IDX_W'(CMD_WORDS - 1)) st_d = S_OUT;
        else begin
          st_d  = S_REQ;
          idx_d = idx_q + 1'b1;
        end
      end
      S_OUT:  if (cmd_ready_i) st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= S_IDLE;
      idx_q <= '0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
    end
  end

  assign mem_req_o   = (st_q == S_REQ) && !err_i;
  assign mem_addr_o  = base_i + ADDR_W'(roff_i) + ADDR_W'({idx_q, 3'b000});
  assign load_o      = (st_q == S_WAIT) && mem_rvalid_i;
  assign idx_o       = idx_q;
  assign cmd_valid_o = (st_q == S_OUT);
  assign adv_o       = cmd_valid_o && cmd_ready_i;
endmodule

// File: rtl/cmdq_asm.sv
module cmdq_asm
  import cmdq_fetch_pkg::*;
#(
  localparam int unsigned IDX_W = $clog2(CMD_WORDS)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        load_i,
  input  logic [IDX_W-1:0]            idx_i,
  input  logic [WORD_W-1:0]           rdata_i,
  output logic [CMD_WORDS*WORD_W-1:0] cmd_o
);
  for (genvar g = 0; g < CMD_WORDS; g++) begin : g_word
    logic [WORD_W-1:0] word_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    word_q <= '0;
      else if (load_i && idx_i == IDX_W'(g))          word_q <= rdata_i;
    end
    assign cmd_o[g*WORD_W +: WORD_W] = word_q;
  end
endmodule

// File: rtl/cmdq_fetch.sv
module cmdq_fetch
  import cmdq_fetch_pkg::*;
#(
  parameter int unsigned ADDR_W = 40,
  parameter int unsigned SIZE_W = 8,
  localparam int unsigned OFF_W = SIZE_W + PAGE_LG,
  localparam int unsigned CMD_W = CMD_WORDS * WORD_W,
  localparam int unsigned IDX_W = $clog2(CMD_WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [63:0]       reg_wdata_i,
  output logic [63:0]       reg_rdata_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_gnt_i,
  input  logic              mem_rvalid_i,
  input  logic [63:0]       mem_rdata_i,
  output logic              cmd_valid_o,
  input  logic              cmd_ready_i,
  output logic [CMD_W-1:0]  cmd_o,
  output logic              idle_o,
  output logic              err_o
);
  logic [ADDR_W-1:0] base;
  logic [OFF_W-1:0]  rd_off;
  logic [OFF_W:0]    q_len;
  logic              start_ok, adv, load;
  logic [IDX_W-1:0]  idx;

  cmdq_regs #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) regs_i (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .adv_i(adv), .base_o(base), .roff_o(rd_off), .qlen_o(q_len),
    .start_ok_o(start_ok), .idle_o(idle_o), .err_o(err_o)
  );

  cmdq_seq #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) seq_i (
    .clk_i, .rst_ni,
    .start_ok_i(start_ok), .err_i(err_o), .base_i(base), .roff_i(rd_off),
    .mem_req_o, .mem_addr_o, .mem_gnt_i, .mem_rvalid_i,
    .load_o(load), .idx_o(idx),
    .cmd_valid_o, .cmd_ready_i, .adv_o(adv)
  );

  cmdq_asm asm_i (
    .clk_i, .rst_ni,
    .load_i(load), .idx_i(idx), .rdata_i(mem_rdata_i), .cmd_o
  );
endmodule

// File: rtl/cmdq_fetch_chk.sv
module cmdq_fetch_chk #(
  parameter int unsigned ADDR_W = 40,
  parameter int unsigned OFF_W  = 20,
  parameter int unsigned CMD_W  = 256
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mem_req_o,
  input logic              mem_gnt_i,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              cmd_valid_o,
  input logic              cmd_ready_i,
  input logic [CMD_W-1:0]  cmd_o,
  input logic              err_o,
  input logic [OFF_W-1:0]  rd_off
);
  // R3
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_gnt_i) |=> (err_o || (mem_req_o && $stable(mem_addr_o))));
  // R3
  word_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (mem_addr_o[2:0] == 3'b000));
  // R5
  cmd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && !cmd_ready_i) |=> (cmd_valid_o && $stable(cmd_o)));
  // R6
  roff_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cmd_valid_o && cmd_ready_i) |=> $stable(rd_off));
  // R6
  roff_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_off[4:0] == 5'd0);
  // R9
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
  // R9
  err_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !mem_req_o);
endmodule

bind cmdq_fetch cmdq_fetch_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .CMD_W(CMD_W)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .mem_req_o(mem_req_o), .mem_gnt_i(mem_gnt_i),
  .mem_addr_o(mem_addr_o), .cmd_valid_o(cmd_valid_o), .cmd_ready_i(cmd_ready_i),
  .cmd_o(cmd_o), .err_o(err_o), .rd_off(rd_off)
);

// File: tb/cmdq_fetch_tb_top.sv
module cmdq_fetch_tb_top;
  localparam int ADDR_W = 40;
  localparam int SIZE_W = 8;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic reg_we_i = 1'b0;
  logic [1:0] reg_addr_i = '0;
  logic [63:0] reg_wdata_i = '0, reg_rdata_o;
  logic mem_req_o, mem_gnt_i = 1'b0, mem_rvalid_i = 1'b0;
  logic [ADDR_W-1:0] mem_addr_o;
  logic [63:0] mem_rdata_i = '0;
  logic cmd_valid_o, cmd_ready_i = 1'b0, idle_o, err_o;
  logic [255:0] cmd_o;

  int checks = 0, errors = 0, req_cycles = 0, n_acc = 0;
  bit done = 0;
  logic [63:0] base_a;
  int qlen, exp_roff, widx;

  always #5 clk_i = ~clk_i;

  cmdq_fetch #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) dut_i (.*);

  function automatic logic [63:0] mdata(logic [63:0] a);
    return {a[31:0] ^ 32'hA5C3_0F1E, a[31:0] + 32'h0000_1234};
  endfunction

  task automatic chk(string r, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [63:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [63:0] d);
    @(negedge clk_i);
    reg_addr_i = a;
    #1 d = reg_rdata_o;
  endtask

  task automatic set_ring(logic [63:0] b, int size, bit v);
    base_a = b;
    qlen = (size + 1) * 4096;
    wr(2'd1, {v, 63'(b) | 63'(size)});
  endtask

  task automatic drain();
    @(negedge clk_i);
    while (!idle_o) @(negedge clk_i);
    repeat (2) @(negedge clk_i);
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    exp_roff = 0; widx = 0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  // memory responder
  initial begin
    logic [63:0] a;
    forever begin
      @(negedge clk_i);
      if (mem_req_o) begin
        req_cycles++;
        if ($urandom % 4 != 0) begin
          mem_gnt_i = 1'b1;
          a = 64'(mem_addr_o);
          // R3: ordered word addresses
          chk("R3 addr", a, base_a + 64'(exp_roff) + 64'(8 * widx));
          widx++;
          @(negedge clk_i);
          mem_gnt_i = 1'b0;
          repeat ($urandom % 3) @(negedge clk_i);
          mem_rvalid_i = 1'b1; mem_rdata_i = mdata(a);
          @(negedge clk_i);
          mem_rvalid_i = 1'b0;
        end
      end
    end
  end

  // executor with random backpressure
  initial begin
    forever begin
      @(negedge clk_i);
      cmd_ready_i = 1'b0;
      if (cmd_valid_o) begin
        // R4 and R5: content held and placed little-endian
        for (int i = 0; i < 4; i++)
          chk("R4/R5 cmd word", cmd_o[64*i +: 64], mdata(base_a + 64'(exp_roff) + 64'(8 * i)));
        if ($urandom % 3 != 0) begin
          cmd_ready_i = 1'b1;
          exp_roff = (exp_roff + 32) % qlen;
          widx = 0;
          n_acc++;
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] v;
    int rc, w, na;
    void'($urandom(32'd1234));
    exp_roff = 0; widx = 0; qlen = 4096; base_a = 64'h12_3456_7000;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state
    #1;
    chk("R1 idle", 64'(idle_o), 1);
    chk("R1 err", 64'(err_o), 0);
    chk("R1 req", 64'(mem_req_o), 0);
    chk("R1 cmd_valid", 64'(cmd_valid_o), 0);
    rd(2'd0, v); chk("R1 ctrl", v, 0);
    rd(2'd2, v); chk("R1 woff", v, 0);
    rd(2'd3, v); chk("R1 roff", v, 0);

    // R2: pending but enable clear, then valid clear
    set_ring(64'h12_3456_7000, 0, 1'b1);
    wr(2'd2, 64'd64);
    rc = req_cycles;
    repeat (20) @(negedge clk_i);
    chk("R2 no fetch without enable", 64'(req_cycles - rc), 0);
    // R7: offsets differ -> not idle
    chk("R7 pending not idle", 64'(idle_o), 0);
    set_ring(64'h12_3456_7000, 0, 1'b0);
    wr(2'd0, 64'd1);
    rc = req_cycles;
    repeat (20) @(negedge clk_i);
    chk("R2 no fetch without valid", 64'(req_cycles - rc), 0);
    set_ring(64'h12_3456_7000, 0, 1'b1);
    drain();
    rd(2'd3, v); chk("R2 roff after fetch", v, 64);
    chk("R2 commands accepted", 64'(n_acc), 2);
    chk("R7 idle when equal", 64'(idle_o), 1);

    // R6 wrap over ring end
    wr(2'd2, 64'd4064);
    drain();
    rd(2'd3, v); chk("R6 roff near end", v, 4064);
    wr(2'd2, 64'd32);
    drain();
    rd(2'd3, v); chk("R6 roff after wrap", v, 32);
    chk("R6 model roff", 64'(exp_roff), 32);

    // R8 low bits dropped
    wr(2'd2, 64'd103);
    rd(2'd2, v); chk("R8 woff masked", v, 96);
    drain();
    rd(2'd3, v); chk("R8 roff reaches masked", v, 96);

    // R10 consumer offset read-only
    wr(2'd3, 64'd512);
    rd(2'd3, v); chk("R10 roff unchanged", v, 96);
    chk("R10 idle unchanged", 64'(idle_o), 1);

    // random producer offsets over a two-page ring
    set_ring(64'h0A_BCDE_0000, 1, 1'b1);
    do_reset();
    set_ring(64'h0A_BCDE_0000, 1, 1'b1);
    wr(2'd0, 64'd1);
    for (int k = 0; k < 5; k++) begin
      w = int'($urandom % (qlen / 32)) * 32;
      wr(2'd2, 64'(w) | 64'($urandom % 32));
      drain();
      rd(2'd3, v); chk("R6 random roff", v, 64'(w));
      chk("R7 random idle", 64'(idle_o), 1);
    end

    // R9 out-of-range producer offset
    set_ring(64'h12_3456_7000, 0, 1'b1);
    do_reset();
    set_ring(64'h12_3456_7000, 0, 1'b1);
    wr(2'd0, 64'd1);
    na = n_acc;
    wr(2'd2, 64'd4096);
    rc = req_cycles;
    repeat (30) @(negedge clk_i);
    chk("R9 err set", 64'(err_o), 1);
    chk("R9 no fetch", 64'(req_cycles - rc), 0);
    chk("R9 no command", 64'(n_acc - na), 0);
    wr(2'd2, 64'd64);
    repeat (10) @(negedge clk_i);
    chk("R9 err sticky", 64'(err_o), 1);
    chk("R9 still no fetch", 64'(req_cycles - rc), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule